// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gives one processor core a small set of hardware counters for profiling. It has two event counters and one cycle counter, each 32 bits wide. Each event counter has an 8-bit selector that picks one line of a vector of single-cycle event pulses. The cycle counter advances on every clock, or once every 64 clocks when the divider is on. All counting stops when the global enable is low.

Software reaches the block through a simple register port. Address 0 is the control word, and addresses 1 to 3 are the three counters, which can be read and loaded. A profiler typically loads a counter with the negated sampling period N. The counter then wraps after exactly N counts and sets its sticky overflow flag. A level interrupt goes to the core while any flagged counter has its interrupt enable set. The handler reads the control word and writes the same value back, which clears exactly the flags it saw.

Top module: `perf_monitor_unit`

## Requirements
- R1: The register addresses are: 0 for the control word, 1 for event counter 0, 2 for event counter 1, and 3 for the cycle counter. A write to addresses 1 to 3 loads that counter, and a read at the same address returns its value.
- R2: The control word fields are:
  - global enable at bit 0
  - cycle divider at bit 3
  - interrupt enables at bits 6:4
  - overflow flags at bits 10:8
  - event select for counter 1 at bits 19:12
  - event select for counter 0 at bits 27:20

  The interrupt enables and the overflow flags are ordered event counter 0, event counter 1, cycle counter, from the low bit upward. The writable fields read back as written.
- R3: Bits 31:28, bit 11 and bit 7 of the control word always read 0, whatever was written to them. The two reset bits (1 and 2) also always read 0.
- R4: Counters change only while the global enable is 1. Clearing the enable freezes all three counters at their current values.
- R5: An event counter increments on each clock edge at which the input line picked by its selector is high. A selector value of NUM_EVENTS or above never counts.
- R6: While enabled, the cycle counter increments on every clock. When the divider bit is 1, it increments once every 64 enabled clocks instead.
- R7: Writing a control word with bit 1 set zeroes both event counters. Writing one with bit 2 set zeroes the cycle counter. A reset applied in the same cycle as a count wins over the count.
- R8: A counter load written in the same cycle as an increment of that counter wins: the counter takes the loaded value.
- R9: A counter sets its overflow flag on the increment that wraps it from 0xFFFFFFFF to 0. A counter loaded with the two's complement of N flags after exactly N counts.
- R10: Overflow flags are sticky. Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R11: The interrupt output is high exactly while some counter has both its overflow flag and its interrupt enable set.
- R12: After reset, the control word, all three counters and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 event counter 0, 2 event counter 1, 3 cycle counter |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| evt_in | input | NUM_EVENTS | Single-cycle event pulses |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a counter wrap that coincides with a software write clearing the same overflow flag. The bench sets it up by loading event counter 0 with 0xFFFFFFFF. On a single clock it then drives the selected event line together with a control write that has the flag bit set, and checks that the flag survives. The divider is reached by letting 63 enabled clocks pass without a count and then checking that the 64th gives one. Load-versus-increment and reset-versus-count priority are produced by driving a counter write or reset bit on the same edge as an event pulse.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int CTRL_W   = 32;
   localparam int NUM_CNT  = 3;
   localparam int SEL_W    = 8;
   localparam int BIT_EN   = 0;
   localparam int BIT_EVRST = 1;
   localparam int BIT_CYRST = 2;
   localparam int BIT_DIV  = 3;
   localparam int IEN_LSB  = 4;
   localparam int OVF_LSB  = 8;
   localparam int SEL1_LSB = 12;
   localparam int SEL0_LSB = 20;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_EV0  = 2'd1,
      REG_EV1  = 2'd2,
      REG_CYC  = 2'd3
   } pmu_reg_e;
endpackage

// File: rtl/pmu_evsel.sv
module pmu_evsel #(
   parameter int NUM_EVENTS = 16,
   parameter int SEL_W      = 8
) (
   input  logic [SEL_W-1:0]      sel,
   input  logic [NUM_EVENTS-1:0] evt,
   output logic                  hit
);
   localparam int IDX_W = $clog2(NUM_EVENTS);
   localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_EVENTS);

   generate
      if (NUM_EVENTS < 2 || NUM_EVENTS > (1 << SEL_W)) begin : g_bad_events
         $error("pmu_evsel: NUM_EVENTS out of range");
      end
   endgenerate

   logic in_range;
   assign in_range = ({1'b0, sel} < LIMIT);
   assign hit      = in_range ? evt[sel[IDX_W-1:0]] : 1'b0;
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
   parameter int DIV_LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic tick
);
   generate
      if (DIV_LOG2 < 1) begin : g_bad_div
         $error("pmu_prescale: DIV_LOG2 must be at least 1");
      end
   endgenerate

   logic [DIV_LOG2-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (clear)  pre_q <= '0;
      else if (run)    pre_q <= pre_q + DIV_LOG2'(1);
   end

   assign tick = run & (&pre_q) & ~clear;

   assert_tick_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (load)  cnt_q <= load_val;
      else if (inc)   cnt_q <= cnt_q + CNT_W'(1);
   end

   assign count = cnt_q;
   assign wrap  = inc & ~clear & ~load & (&cnt_q);

   assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));
   assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear) |=> (count == $past(load_val)));
   assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
   import pmu_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [CTRL_W-1:0]  wdata,
   input  logic [NUM_CNT-1:0] wrap,
   output logic [CTRL_W-1:0]  rdata,
   output logic               enable,
   output logic               div_mode,
   output logic [SEL_W-1:0]   sel0,
   output logic [SEL_W-1:0]   sel1,
   output logic               ev_clear,
   output logic               cyc_clear,
   output logic               irq
);
   logic               en_q, div_q;
   logic [NUM_CNT-1:0] ien_q, ovf_q;
   logic [SEL_W-1:0]   sel0_q, sel1_q;
   logic [NUM_CNT-1:0] flag_wipe;

   assign flag_wipe = wr_en ? wdata[OVF_LSB +: NUM_CNT] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         div_q  <= 1'b0;
         ien_q  <= '0;
         ovf_q  <= '0;
         sel0_q <= '0;
         sel1_q <= '0;
      end else begin
         if (wr_en) begin
            en_q   <= wdata[BIT_EN];
            div_q  <= wdata[BIT_DIV];
            ien_q  <= wdata[IEN_LSB +: NUM_CNT];
            sel0_q <= wdata[SEL0_LSB +: SEL_W];
            sel1_q <= wdata[SEL1_LSB +: SEL_W];
         end
         ovf_q <= (ovf_q & ~flag_wipe) | wrap;
      end
   end

   logic unused_rsvd;
   assign unused_rsvd = ^{wdata[31:28], wdata[11], wdata[7]};

   always_comb begin
      rdata                          = '0;
      rdata[BIT_EN]                  = en_q;
      rdata[BIT_DIV]                 = div_q;
      rdata[IEN_LSB +: NUM_CNT]      = ien_q;
      rdata[OVF_LSB +: NUM_CNT]      = ovf_q;
      rdata[SEL1_LSB +: SEL_W]       = sel1_q;
      rdata[SEL0_LSB +: SEL_W]       = sel0_q;
   end

   assign enable    = en_q;
   assign div_mode  = div_q;
   assign sel0      = sel0_q;
   assign sel1      = sel1_q;
   assign ev_clear  = wr_en & wdata[BIT_EVRST];
   assign cyc_clear = wr_en & wdata[BIT_CYRST];
   assign irq       = |(ovf_q & ien_q);

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_flag_chk
         assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[k] && !(wr_en && wdata[OVF_LSB+k])) |=> ovf_q[k]);
         assert_wrap_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[k] |=> ovf_q[k]);
         assert_flag_needs_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovf_q[k] && !wrap[k]) |=> !ovf_q[k]);
      end
   endgenerate
endmodule

// File: rtl/perf_monitor_unit.sv
module perf_monitor_unit
   import pmu_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int NUM_EVENTS = 16,
   parameter int DIV_LOG2   = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            reg_addr,
   input  logic                  reg_wr,
   input  logic [CTRL_W-1:0]     reg_wdata,
   output logic [CTRL_W-1:0]     reg_rdata,
   input  logic [NUM_EVENTS-1:0] evt_in,
   output logic                  irq
);
   generate
      if (CNT_W < 1 || CNT_W > CTRL_W) begin : g_bad_cnt_w
         $error("perf_monitor_unit: CNT_W must be 1..32");
      end
   endgenerate

   logic [CTRL_W-1:0]  ctrl_rd;
   logic               en, div_mode, ev_clear, cyc_clear, cyc_tick;
   logic [SEL_W-1:0]   sel [2];
   logic [NUM_CNT-1:0] inc_vec, wrap_vec;
   logic [CNT_W-1:0]   cnt_val [NUM_CNT];

   pmu_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr && reg_addr == REG_CTRL),
      .wdata     (reg_wdata),
      .wrap      (wrap_vec),
      .rdata     (ctrl_rd),
      .enable    (en),
      .div_mode  (div_mode),
      .sel0      (sel[0]),
      .sel1      (sel[1]),
      .ev_clear  (ev_clear),
      .cyc_clear (cyc_clear),
      .irq       (irq)
   );

   pmu_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en & div_mode),
      .clear (cyc_clear),
      .tick  (cyc_tick)
   );

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
         logic clr_k;
         if (k < 2) begin : g_event
            logic hit;
            pmu_evsel #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_sel (
               .sel (sel[k]),
               .evt (evt_in),
               .hit (hit)
            );
            assign inc_vec[k] = en & hit;
            assign clr_k      = ev_clear;
         end else begin : g_cycle
            assign inc_vec[k] = en & (div_mode ? cyc_tick : 1'b1);
            assign clr_k      = cyc_clear;
         end

         pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clr_k),
            .load     (reg_wr && reg_addr == 2'(k + 1)),
            .load_val (reg_wdata[CNT_W-1:0]),
            .inc      (inc_vec[k]),
            .count    (cnt_val[k]),
            .wrap     (wrap_vec[k])
         );

         assert_frozen_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!en && !reg_wr) |=> $stable(cnt_val[k]));
      end
   endgenerate

   always_comb begin
      case (reg_addr)
         REG_CTRL: reg_rdata = ctrl_rd;
         REG_EV0:  reg_rdata = CTRL_W'(cnt_val[0]);
         REG_EV1:  reg_rdata = CTRL_W'(cnt_val[1]);
         default:  reg_rdata = CTRL_W'(cnt_val[2]);
      endcase
   end

   assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == REG_CTRL) |-> (reg_rdata[31:28] == 4'd0 && !reg_rdata[11] && !reg_rdata[7]));
endmodule

// File: tb/tb_perf_monitor_unit.sv
module tb_perf_monitor_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] evt_in = '0;
   logic        irq;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   perf_monitor_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
   );

   // op: 0 write, 1 read-compare, 2 run data cycles with evt, 3 irq compare
   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [15:0] evt;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 49;
   localparam vec_t TBL [NV] = '{
      '{2'd0, 2'd0, 32'hF03058F0, 32'h0,        16'h0,    4'd3},  // R3 reserved written
      '{2'd1, 2'd0, 32'h0,        32'h00305070, 16'h0,    4'd2},  // R2 readback
      '{2'd0, 2'd1, 32'hFFFFFFFE, 32'h0,        16'h0,    4'd1},  // R1
      '{2'd0, 2'd2, 32'h00000010, 32'h0,        16'h0,    4'd1},
      '{2'd0, 2'd3, 32'h00000000, 32'h0,        16'h0,    4'd1},
      '{2'd1, 2'd1, 32'h0,        32'hFFFFFFFE, 16'h0,    4'd1},
      '{2'd2, 2'd0, 32'd3,        32'h0,        16'h0028, 4'd4},  // R4 disabled
      '{2'd1, 2'd1, 32'h0,        32'hFFFFFFFE, 16'h0,    4'd4},
      '{2'd1, 2'd2, 32'h0,        32'h00000010, 16'h0,    4'd4},
      '{2'd0, 2'd0, 32'h00305071, 32'h0,        16'h0,    4'd4},
      '{2'd2, 2'd0, 32'd1,        32'h0,        16'h0008, 4'd5},  // R5
      '{2'd1, 2'd1, 32'h0,        32'hFFFFFFFF, 16'h0,    4'd5},
      '{2'd1, 2'd2, 32'h0,        32'h00000010, 16'h0,    4'd5},
      '{2'd2, 2'd0, 32'd1,        32'h0,        16'h0028, 4'd9},  // R9 wrap
      '{2'd1, 2'd1, 32'h0,        32'h00000000, 16'h0,    4'd9},
      '{2'd1, 2'd0, 32'h0,        32'h00305171, 16'h0,    4'd9},
      '{2'd3, 2'd0, 32'h0,        32'h1,        16'h0,    4'd11}, // R11
      '{2'd1, 2'd2, 32'h0,        32'h00000011, 16'h0,    4'd5},
      '{2'd1, 2'd3, 32'h0,        32'h00000002, 16'h0,    4'd6},  // R6
      '{2'd2, 2'd0, 32'd2,        32'h0,        16'h0020, 4'd5},
      '{2'd1, 2'd2, 32'h0,        32'h00000013, 16'h0,    4'd5},
      '{2'd1, 2'd3, 32'h0,        32'h00000004, 16'h0,    4'd6},
      '{2'd0, 2'd0, 32'h00305070, 32'h0,        16'h0,    4'd10}, // R10 write 0 keeps
      '{2'd1, 2'd0, 32'h0,        32'h00305170, 16'h0,    4'd10},
      '{2'd1, 2'd3, 32'h0,        32'h00000005, 16'h0,    4'd4},
      '{2'd2, 2'd0, 32'd4,        32'h0,        16'hFFFF, 4'd4},
      '{2'd1, 2'd3, 32'h0,        32'h00000005, 16'h0,    4'd4},
      '{2'd1, 2'd2, 32'h0,        32'h00000013, 16'h0,    4'd4},
      '{2'd0, 2'd0, 32'h00305170, 32'h0,        16'h0,    4'd10}, // write 1 clears
      '{2'd1, 2'd0, 32'h0,        32'h00305070, 16'h0,    4'd10},
      '{2'd3, 2'd0, 32'h0,        32'h0,        16'h0,    4'd11},
      '{2'd0, 2'd0, 32'h02005001, 32'h0,        16'h0,    4'd5},  // selector 32 out of range
      '{2'd2, 2'd0, 32'd3,        32'h0,        16'hFFFF, 4'd5},
      '{2'd1, 2'd1, 32'h0,        32'h00000000, 16'h0,    4'd5},
      '{2'd1, 2'd2, 32'h0,        32'h00000016, 16'h0,    4'd5},
      '{2'd1, 2'd3, 32'h0,        32'h00000008, 16'h0,    4'd6},
      '{2'd0, 2'd0, 32'h02005003, 32'h0,        16'h0,    4'd7},  // R7 event reset
      '{2'd1, 2'd2, 32'h0,        32'h00000000, 16'h0,    4'd7},
      '{2'd1, 2'd0, 32'h0,        32'h02005001, 16'h0,    4'd3},
      '{2'd1, 2'd3, 32'h0,        32'h00000009, 16'h0,    4'd7},
      '{2'd0, 2'd0, 32'h02005005, 32'h0,        16'h0,    4'd7},  // cycle reset beats count
      '{2'd1, 2'd3, 32'h0,        32'h00000000, 16'h0,    4'd7},
      '{2'd0, 2'd0, 32'h02005009, 32'h0,        16'h0,    4'd6},  // divider on
      '{2'd2, 2'd0, 32'd63,       32'h0,        16'h0,    4'd6},
      '{2'd1, 2'd3, 32'h0,        32'h00000001, 16'h0,    4'd6},
      '{2'd2, 2'd0, 32'd1,        32'h0,        16'h0,    4'd6},
      '{2'd1, 2'd3, 32'h0,        32'h00000002, 16'h0,    4'd6},
      '{2'd0, 2'd0, 32'h02005000, 32'h0,        16'h0,    4'd4},
      '{2'd1, 2'd3, 32'h0,        32'h00000002, 16'h0,    4'd4}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic run(input int n, input logic [15:0] e);
      evt_in = e;
      repeat (n) @(negedge clk);
      evt_in = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      for (int a = 0; a < 4; a++) rd(2'(a), 32'h0, "R12");
      check("R12 irq", {31'b0, irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d row%0d", TBL[i].req, i);
         case (TBL[i].op)
            2'd0: wr(TBL[i].addr, TBL[i].data);
            2'd1: rd(TBL[i].addr, TBL[i].exp, tag);
            2'd2: run(int'(TBL[i].data), TBL[i].evt);
            default: check(tag, {31'b0, irq}, TBL[i].exp);
         endcase
      end

      // R8: load and increment of event counter 1 on the same edge
      wr(2'd0, 32'h00305071);
      reg_addr = 2'd2; reg_wdata = 32'h00000100; reg_wr = 1'b1; evt_in = 16'h0020;
      @(negedge clk);
      reg_wr = 1'b0; evt_in = '0;
      rd(2'd2, 32'h00000100, "R8 load wins");
      run(1, 16'h0020);
      rd(2'd2, 32'h00000101, "R8 counts after load");

      // R9: period of 5 events
      wr(2'd1, 32'hFFFFFFFB);
      run(4, 16'h0008);
      check("R9 no irq before N", {31'b0, irq}, 32'h0);
      rd(2'd0, 32'h00305071, "R9 no flag before N");
      run(1, 16'h0008);
      check("R9 irq at N", {31'b0, irq}, 32'h1);
      rd(2'd1, 32'h0, "R9 wrapped to zero");

      // R10: writing back the read value clears exactly the set flags
      reg_addr = 2'd0; #1; snap = reg_rdata;
      check("R10 snapshot", snap, 32'h00305171);
      @(negedge clk);
      wr(2'd0, snap);
      rd(2'd0, 32'h00305071, "R10 writeback clears");
      check("R10 irq low", {31'b0, irq}, 32'h0);

      // R10: wrap and clear on the same edge, flag stays set
      wr(2'd1, 32'hFFFFFFFF);
      reg_addr = 2'd0; reg_wdata = 32'h00305171; reg_wr = 1'b1; evt_in = 16'h0008;
      @(negedge clk);
      reg_wr = 1'b0; evt_in = '0;
      rd(2'd0, 32'h00305171, "R10 set beats clear");
      wr(2'd0, 32'h00305171);
      rd(2'd0, 32'h00305071, "R10 cleared");

      // R9 / R11: cycle counter wrap with only its interrupt enabled
      wr(2'd0, 32'h00305041);
      wr(2'd3, 32'hFFFFFFFF);
      run(1, 16'h0);
      rd(2'd0, 32'h00305441, "R9 cycle flag");
      check("R11 irq from cycle counter", {31'b0, irq}, 32'h1);
      wr(2'd0, 32'h00305001);
      rd(2'd0, 32'h00305401, "R11 flag kept");
      check("R11 irq masked", {31'b0, irq}, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule